// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Source

This block is a register-programmed watchdog. Software loads a 32-bit duration, chooses where the countdown tick comes from and sets the enable bit. The tick can come from a fixed reference clock, which reaches the block as a one-cycle strobe synchronous to the system clock. It can also come from the system clock itself, divided by a power of two that software picks with a 3-bit ratio field.

Each tick lowers the count by one. When the count moves from one to zero, a sticky expired flag is raised and a single-cycle reset request is produced. That request leaves the block on its reset output only when two independent controls both allow it: a local unmask bit must be set, and a watchdog bit in a global mask register must be clear. Software clears the expired flag by writing a zero to its bit in the status register.

Top module: `wdog_timer`

## Requirements
- R1: After reset: control, status, duration, live count and unmask all read 0. The global mask reads 0x0000_0400, with its watchdog bit set so the reset is blocked. The reset output is low.
- R2: The register map is as follows. Control is at 0x00, with enable at bit 8, reference select at bit 10 and ratio R at bits 18:16. Status is at 0x04, with the expired flag at bit 31. Duration is at 0x34. The live count is at 0x38 and is read-only. Unmask is at 0x40, with its bit at 8. The global mask is at 0x48, with its bit at 10. Undefined bits read as 0.
- R3: With reference select at 0 and enable at 1, the count drops by one every 2^(R+1) clocks. The first drop happens 2^(R+1) clocks after the control write.
- R4: With reference select at 1, the count drops by one on each clock in which ref_tick is high, and the ratio field has no effect.
- R5: The step from 1 to 0 sets the expired flag on the same edge and raises the request for exactly one cycle. After that the count stays at 0 and causes no further requests. A count of 0 never expires.
- R6: The expired flag is sticky. Writing 0 to status bit 31 clears it. Writing 1 to that bit, or writing any other register, leaves it unchanged.
- R7: wdog_rst pulses on an expiry only when unmask bit 8 is 1 and global mask bit 10 is 0. With any other setting of the two bits it stays low.
- R8: With enable at 0 the count holds. Every control write restarts the prescaler phase.
- R9: A duration write loads the count on the same edge, whether or not the timer is running. The load takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference-clock strobe, one cycle per reference period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wdog_rst | output | 1 | Gated watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a 3-bit ratio. This makes the largest divisor 256 clocks. Because durations of a few ticks are used, every one of the eight ratios can be timed to the exact edge within a short run. Because the reference tick is a strobe driven by the bench, the reference rate is arbitrary, and the bench can step the count one tick at a time. This lets it cover all four mask combinations, the flag's sticky behaviour and freezing with the count stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W  = 32;
    localparam int RATIO_W = 3;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STAT   = 8'h04;
    localparam logic [7:0] OFS_DUR    = 8'h34;
    localparam logic [7:0] OFS_CNT    = 8'h38;
    localparam logic [7:0] OFS_UNMASK = 8'h40;
    localparam logic [7:0] OFS_GMASK  = 8'h48;

    localparam int B_EN     = 8;
    localparam int B_REF    = 10;
    localparam int B_RLO    = 16;
    localparam int B_EXP    = 31;
    localparam int B_UNMASK = 8;
    localparam int B_GMASK  = 10;

    typedef struct packed {
        logic               en;
        logic               refsel;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              expired_i,
    output logic [DATA_W-1:0] reg_rdata,
    output ctrl_t             ctrl_o,
    output logic              unmask_o,
    output logic              gmask_o,
    output logic              ctrl_wr_o,
    output logic              dur_wr_o,
    output logic              stat_clr_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              unmask;
        logic              gmask;
        logic [CNT_W-1:0]  dur;
    } regs_t;

    regs_t st_d, st_q;

    logic sel_ctrl, sel_stat, sel_dur, sel_cnt, sel_unmask, sel_gmask;

    always_comb begin
        sel_ctrl   = reg_addr == ADDR_W'(OFS_CTRL);
        sel_stat   = reg_addr == ADDR_W'(OFS_STAT);
        sel_dur    = reg_addr == ADDR_W'(OFS_DUR);
        sel_cnt    = reg_addr == ADDR_W'(OFS_CNT);
        sel_unmask = reg_addr == ADDR_W'(OFS_UNMASK);
        sel_gmask  = reg_addr == ADDR_W'(OFS_GMASK);
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && sel_ctrl) begin
            st_d.ctrl.en     = reg_wdata[B_EN];
            st_d.ctrl.refsel = reg_wdata[B_REF];
            st_d.ctrl.ratio  = reg_wdata[B_RLO +: RATIO_W];
        end
        if (reg_wr && sel_unmask) st_d.unmask = reg_wdata[B_UNMASK];
        if (reg_wr && sel_gmask)  st_d.gmask  = reg_wdata[B_GMASK];
        if (reg_wr && sel_dur)    st_d.dur    = reg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[B_EN]              = st_q.ctrl.en;
            reg_rdata[B_REF]             = st_q.ctrl.refsel;
            reg_rdata[B_RLO +: RATIO_W]  = st_q.ctrl.ratio;
        end
        if (sel_stat)   reg_rdata[B_EXP]    = expired_i;
        if (sel_dur)    reg_rdata           = DATA_W'(st_q.dur);
        if (sel_cnt)    reg_rdata           = DATA_W'(cnt_i);
        if (sel_unmask) reg_rdata[B_UNMASK] = st_q.unmask;
        if (sel_gmask)  reg_rdata[B_GMASK]  = st_q.gmask;
    end

    assign ctrl_o     = st_q.ctrl;
    assign unmask_o   = st_q.unmask;
    assign gmask_o    = st_q.gmask;
    assign ctrl_wr_o  = reg_wr && sel_ctrl;
    assign dur_wr_o   = reg_wr && sel_dur;
    assign stat_clr_o = reg_wr && sel_stat && !reg_wdata[B_EXP];
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               refsel,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               ref_tick,
    output logic               tick
);
    localparam int PRE_W = 1 << RATIO_W;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] last;

    always_comb begin
        span = (PRE_W+1)'(1) << ({1'b0, ratio} + (RATIO_W+1)'(1));
        last = PRE_W'(span - (PRE_W+1)'(1));
        if (restart || pre_q == last) pre_d = '0;
        else                          pre_d = pre_q + PRE_W'(1);
        tick = refsel ? ref_tick : (pre_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             expired,
    output logic             req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
        logic             req;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d         = cd_q;
        cd_d.req     = 1'b0;
        cd_d.expired = clr ? 1'b0 : cd_q.expired;
        if (load) begin
            cd_d.cnt = load_val;
        end else if (en && tick && cd_q.cnt != '0) begin
            cd_d.cnt = cd_q.cnt - CNT_W'(1);
            if (cd_q.cnt == CNT_W'(1)) begin
                cd_d.expired = 1'b1;
                cd_d.req     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign cnt     = cd_q.cnt;
    assign expired = cd_q.expired;
    assign req     = cd_q.req;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdog_rst
);
    ctrl_t            ctrl_w;
    logic             unmask_w, gmask_w;
    logic             ctrl_wr_w, dur_wr_w, stat_clr_w;
    logic             tick_w, req_w, expired_w;
    logic [CNT_W-1:0] cnt_w;

    wdog_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_i     (cnt_w),
        .expired_i (expired_w),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl_w),
        .unmask_o  (unmask_w),
        .gmask_o   (gmask_w),
        .ctrl_wr_o (ctrl_wr_w),
        .dur_wr_o  (dur_wr_w),
        .stat_clr_o(stat_clr_w)
    );

    wdog_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr_w),
        .refsel  (ctrl_w.refsel),
        .ratio   (ctrl_w.ratio),
        .ref_tick(ref_tick),
        .tick    (tick_w)
    );

    wdog_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_w.en),
        .tick    (tick_w),
        .load    (dur_wr_w),
        .load_val(reg_wdata[CNT_W-1:0]),
        .clr     (stat_clr_w),
        .cnt     (cnt_w),
        .expired (expired_w),
        .req     (req_w)
    );

    assign wdog_rst = req_w && unmask_w && !gmask_w;
endmodule

// File: rtl/wdog_timer_checker.sv
module wdog_timer_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dur_wr,
    input logic             stat_clr,
    input logic             en,
    input logic             unmask,
    input logic             gmask,
    input logic [CNT_W-1:0] cnt,
    input logic             expired,
    input logic             wdog_rst
);
    a_r7_gated_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (unmask && !gmask));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !dur_wr) |=> (cnt == '0));

    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !stat_clr) |=> expired);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !dur_wr) |=> $stable(cnt));

    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !dur_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind wdog_timer wdog_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dur_wr  (dur_wr_w),
    .stat_clr(stat_clr_w),
    .en      (ctrl_w.en),
    .unmask  (unmask_w),
    .gmask   (gmask_w),
    .cnt     (cnt_w),
    .expired (expired_w),
    .wdog_rst(wdog_rst)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        wdog_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_DUR = 8'h34,
                           A_CNT = 8'h38, A_UM = 8'h40, A_GM = 8'h48;
    localparam logic [31:0] EN = 32'h100, REFS = 32'h400, EXPB = 32'h8000_0000;

    always #10 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wdog_rst(wdog_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_ref();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic t_reset();
        rdchk("R1 ctrl", A_CTRL, 32'h0);
        rdchk("R1 stat", A_STAT, 32'h0);
        rdchk("R1 dur", A_DUR, 32'h0);
        rdchk("R1 cnt", A_CNT, 32'h0);
        rdchk("R1 unmask", A_UM, 32'h0);
        rdchk("R1 gmask", A_GM, 32'h400);
        chk("R1 rst out", {31'h0, wdog_rst}, 32'h0);
    endtask

    task automatic t_regmap();
        wr(A_CTRL, 32'hFFFF_FFFF);
        rdchk("R2 ctrl bits", A_CTRL, 32'h0007_0500);
        wr(A_CTRL, 32'h0);
        wr(A_DUR, 32'hDEAD_BEEF);
        rdchk("R2 dur readback", A_DUR, 32'hDEAD_BEEF);
        rdchk("R9 load on write", A_CNT, 32'hDEAD_BEEF);
        wr(A_UM, 32'hFFFF_FFFF);
        rdchk("R2 unmask bits", A_UM, 32'h100);
        wr(A_GM, 32'h0);
        rdchk("R2 gmask clear", A_GM, 32'h0);
        wr(A_GM, 32'hFFFF_FFFF);
        rdchk("R2 gmask bits", A_GM, 32'h400);
        wr(A_CNT, 32'h5);
        rdchk("R2 cnt read-only", A_CNT, 32'hDEAD_BEEF);
        wr(A_DUR, 32'h0);
    endtask

    task automatic t_ratio(input int r);
        int n;
        n = 1 << (r + 1);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h0);
        wr(A_DUR, 32'd3);
        wr(A_CTRL, EN | (32'(r) << 16));
        repeat (n - 1) @(negedge clk);
        rdchk($sformatf("R3 r=%0d before first tick", r), A_CNT, 32'd3);
        @(negedge clk);
        rdchk($sformatf("R3 r=%0d first tick", r), A_CNT, 32'd2);
        repeat (2 * n - 1) @(negedge clk);
        rdchk($sformatf("R5 r=%0d not yet expired", r), A_STAT, 32'h0);
        chk($sformatf("R7 r=%0d no early rst", r), {31'h0, wdog_rst}, 32'h0);
        @(negedge clk);
        rdchk($sformatf("R5 r=%0d expired", r), A_STAT, EXPB);
        chk($sformatf("R7 r=%0d rst pulse", r), {31'h0, wdog_rst}, 32'h1);
        @(negedge clk);
        chk($sformatf("R5 r=%0d single pulse", r), {31'h0, wdog_rst}, 32'h0);
        repeat (3 * n) @(negedge clk);
        rdchk($sformatf("R5 r=%0d stays zero", r), A_CNT, 32'h0);
        chk($sformatf("R5 r=%0d no repeat", r), {31'h0, wdog_rst}, 32'h0);
    endtask

    task automatic t_refclk();
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h0);
        wr(A_DUR, 32'd2);
        wr(A_CTRL, EN | REFS | (32'd7 << 16));
        repeat (40) @(negedge clk);
        rdchk("R4 no tick without strobe", A_CNT, 32'd2);
        pulse_ref();
        rdchk("R4 one strobe one step", A_CNT, 32'd1);
        pulse_ref();
        rdchk("R4 expired by strobe", A_STAT, EXPB);
        chk("R7 rst via ref", {31'h0, wdog_rst}, 32'h1);
    endtask

    task automatic t_masks();
        for (int um = 0; um < 2; um++) begin
            for (int gm = 0; gm < 2; gm++) begin
                wr(A_CTRL, 32'h0);
                wr(A_STAT, 32'h0);
                wr(A_UM, (um != 0) ? 32'h100 : 32'h0);
                wr(A_GM, (gm != 0) ? 32'h400 : 32'h0);
                wr(A_DUR, 32'd1);
                wr(A_CTRL, EN | REFS);
                pulse_ref();
                chk($sformatf("R7 um=%0d gm=%0d", um, gm), {31'h0, wdog_rst},
                    (um == 1 && gm == 0) ? 32'h1 : 32'h0);
                rdchk($sformatf("R5 um=%0d gm=%0d flag", um, gm), A_STAT, EXPB);
                @(negedge clk);
                chk($sformatf("R7 um=%0d gm=%0d after", um, gm), {31'h0, wdog_rst}, 32'h0);
            end
        end
    endtask

    task automatic t_sticky();
        rdchk("R6 flag set", A_STAT, EXPB);
        wr(A_STAT, 32'hFFFF_FFFF);
        rdchk("R6 write one keeps", A_STAT, EXPB);
        wr(A_DUR, 32'd5);
        repeat (10) @(negedge clk);
        rdchk("R6 other write keeps", A_STAT, EXPB);
        wr(A_STAT, 32'h7FFF_FFFF);
        rdchk("R6 write zero clears", A_STAT, 32'h0);
    endtask

    task automatic t_freeze();
        logic [31:0] v0, v1;
        wr(A_CTRL, 32'h0);
        wr(A_DUR, 32'd100);
        wr(A_CTRL, EN);
        repeat (20) @(negedge clk);
        rdchk("R3 ratio0 rate", A_CNT, 32'd90);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v0);
        repeat (30) @(negedge clk);
        rd(A_CNT, v1);
        chk("R8 frozen while disabled", v1, v0);
        wr(A_CTRL, EN | (32'd2 << 16));
        repeat (7) @(negedge clk);
        rdchk("R8 phase restart hold", A_CNT, v0);
        @(negedge clk);
        rdchk("R8 phase restart step", A_CNT, v0 - 32'd1);
        wr(A_DUR, 32'd50);
        rdchk("R9 reload while running", A_CNT, 32'd50);
        wr(A_CTRL, 32'h0);
        wr(A_DUR, 32'd0);
        wr(A_CTRL, EN | REFS);
        pulse_ref();
        rdchk("R5 zero count never expires", A_STAT, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        wr(A_UM, 32'h100);
        wr(A_GM, 32'h0);
        for (int r = 0; r < 8; r++) t_ratio(r);
        t_refclk();
        t_masks();
        t_sticky();
        t_freeze();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule